// File: doc/BRIEF.md
# Hashed Reverse-Map Frame Lookup

This block finds which physical frame, if any, currently holds a given virtual page of a given address space. The translation table is kept in reverse order: it has one slot for every physical frame, and a slot's position is its frame number. Each slot records the owning address-space ID, the virtual page number, a valid flag and a link to the next slot. A small bucket table holds the first slot of each hash chain.

A request carries an (address-space ID, virtual page) pair. The block folds the pair down to a bucket index and reads that bucket's head link. It then follows the chain and examines one slot per clock. It stops at the first valid slot whose stored pair equals the request, or at the chain's end. It answers with a hit flag, the frame number and the number of slots it examined. A chain that never ends is cut off once it has visited as many slots as there are frames, and the answer is flagged as an error.

Software fills both tables through a write port. That port is honoured only while no lookup is in flight. Requests and responses each use a valid/ready handshake.

Top module: `ipt_lookup`

## Requirements
- R1: After reset, `req_ready_o` is 1, `rsp_valid_o` is 0, every slot is invalid and every bucket head holds the end marker, so any lookup misses with a count of 0.
- R2: The bucket index is the XOR fold of the key {asid, vpn} (asid in the upper bits): key bit i is XORed into bucket bit (i mod log2(BUCKETS)).
- R3: On a hit, `rsp_frame_o` is the position of the matching slot, and `rsp_count_o` is its 1-based position along the chain.
- R4: A slot matches only if its valid flag is set and both its stored asid and vpn equal the request's. A non-matching slot, valid or not, is passed over by following its link.
- R5: When the chain ends without a match, `rsp_hit_o` and `rsp_err_o` are 0 and `rsp_count_o` is the number of slots examined. An empty bucket gives a count of 0.
- R6: A link (head or next field, IDX_W+1 bits wide) whose top bit is 1 marks the end of the chain, whatever its low bits hold.
- R7: If FRAMES slots have been examined without a match and the last of them links onward, the lookup stops with `rsp_err_o`=1, `rsp_hit_o`=0 and `rsp_count_o`=FRAMES.
- R8: `rsp_valid_o` rises exactly `rsp_count_o`+1 clock edges after the edge that accepts the request.
- R9: The response fields stay constant while `rsp_valid_o` is 1 and `rsp_ready_i` is 0. `req_ready_o` is 0 from acceptance until the response is taken.
- R10: A table write presented while `req_ready_o` is 0 is dropped and changes no table content.
- R11: With `wr_head_i`=0, a write stores valid, asid, vpn and next into slot `wr_addr_i`. With `wr_head_i`=1, it stores `wr_next_i` as the head of bucket `wr_addr_i[BKT_W-1:0]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Lookup request present |
| req_ready_o | output | 1 | Block idle, request and writes accepted |
| req_asid_i | input | ASID_W | Requested address-space ID |
| req_vpn_i | input | VPN_W | Requested virtual page number |
| rsp_valid_o | output | 1 | Response present |
| rsp_ready_i | input | 1 | Response consumed |
| rsp_hit_o | output | 1 | Match found |
| rsp_err_o | output | 1 | Chain cut off at the visit limit |
| rsp_frame_o | output | IDX_W | Frame number of the match |
| rsp_count_o | output | IDX_W+1 | Slots examined |
| wr_en_i | input | 1 | Table write strobe |
| wr_head_i | input | 1 | 1: write bucket head, 0: write slot |
| wr_addr_i | input | IDX_W | Slot index, or bucket index in its low bits |
| wr_valid_i | input | 1 | Slot valid flag to store |
| wr_asid_i | input | ASID_W | Slot address-space ID to store |
| wr_vpn_i | input | VPN_W | Slot virtual page to store |
| wr_next_i | input | IDX_W+1 | Link to store: slot next field or bucket head |

## Verification
A corrupted chain pointer or a wrong bucket fold shows at the ports on the very next response. The frame comes out wrong, the hit flag flips, or the count of examined slots departs from the chain length the bench computes. A walk state that fails to advance or stop is caught by latency: the response must arrive exactly count+1 edges after acceptance. A write that slips in mid-walk shows on a later lookup of the same key as a changed count or result.

// File: rtl/ipt_pkg.sv
package ipt_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_HEAD, ST_WALK, ST_RESP} walk_st_e;
endpackage

// File: rtl/ipt_hash.sv
module ipt_hash #(
  parameter int ASID_W = 16,
  parameter int VPN_W  = 36,
  parameter int BKT_W  = 6
) (
  input  logic [ASID_W-1:0] asid_i,
  input  logic [VPN_W-1:0]  vpn_i,
  output logic [BKT_W-1:0]  bkt_o
);
  localparam int KEY_W = ASID_W + VPN_W;
  logic [KEY_W-1:0] key;
  assign key = {asid_i, vpn_i};

  always_comb begin
    bkt_o = '0;
    for (int i = 0; i < KEY_W; i++) bkt_o[i % BKT_W] ^= key[i];
  end
endmodule

// File: rtl/ipt_store.sv
module ipt_store #(
  parameter int FRAMES  = 256,
  parameter int BUCKETS = 64,
  parameter int ASID_W  = 16,
  parameter int VPN_W   = 36,
  localparam int IDX_W  = $clog2(FRAMES),
  localparam int BKT_W  = $clog2(BUCKETS),
  localparam int LINK_W = IDX_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              wr_head_i,
  input  logic [IDX_W-1:0]  wr_addr_i,
  input  logic              wr_valid_i,
  input  logic [ASID_W-1:0] wr_asid_i,
  input  logic [VPN_W-1:0]  wr_vpn_i,
  input  logic [LINK_W-1:0] wr_next_i,
  input  logic [BKT_W-1:0]  head_sel_i,
  output logic [LINK_W-1:0] head_o,
  input  logic [IDX_W-1:0]  ent_sel_i,
  output logic              ent_valid_o,
  output logic [ASID_W-1:0] ent_asid_o,
  output logic [VPN_W-1:0]  ent_vpn_o,
  output logic [LINK_W-1:0] ent_next_o
);
  localparam logic [LINK_W-1:0] LINK_END = {1'b1, {IDX_W{1'b0}}};

  logic [LINK_W-1:0] head_q [BUCKETS];
  logic [FRAMES-1:0] vld_q;
  logic [ASID_W-1:0] asid_q [FRAMES];
  logic [VPN_W-1:0]  vpn_q  [FRAMES];
  logic [LINK_W-1:0] next_q [FRAMES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= '0;
      for (int b = 0; b < BUCKETS; b++) head_q[b] <= LINK_END;
    end else if (wr_en_i) begin
      if (wr_head_i) head_q[wr_addr_i[BKT_W-1:0]] <= wr_next_i;
      else           vld_q[wr_addr_i] <= wr_valid_i;
    end
  end

  always_ff @(posedge clk_i) begin
    if (wr_en_i && !wr_head_i) begin
      asid_q[wr_addr_i] <= wr_asid_i;
      vpn_q[wr_addr_i]  <= wr_vpn_i;
      next_q[wr_addr_i] <= wr_next_i;
    end
  end

  assign head_o      = head_q[head_sel_i];
  assign ent_valid_o = vld_q[ent_sel_i];
  assign ent_asid_o  = asid_q[ent_sel_i];
  assign ent_vpn_o   = vpn_q[ent_sel_i];
  assign ent_next_o  = next_q[ent_sel_i];
endmodule

// File: rtl/ipt_walker.sv
module ipt_walker
  import ipt_pkg::*;
#(
  parameter int FRAMES  = 256,
  parameter int BUCKETS = 64,
  parameter int ASID_W  = 16,
  parameter int VPN_W   = 36,
  localparam int IDX_W  = $clog2(FRAMES),
  localparam int BKT_W  = $clog2(BUCKETS),
  localparam int LINK_W = IDX_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [ASID_W-1:0] req_asid_i,
  input  logic [VPN_W-1:0]  req_vpn_i,
  input  logic [BKT_W-1:0]  req_bkt_i,
  output logic              idle_o,
  output logic [BKT_W-1:0]  head_sel_o,
  input  logic [LINK_W-1:0] head_i,
  output logic [IDX_W-1:0]  ent_sel_o,
  input  logic              ent_valid_i,
  input  logic [ASID_W-1:0] ent_asid_i,
  input  logic [VPN_W-1:0]  ent_vpn_i,
  input  logic [LINK_W-1:0] ent_next_i,
  output logic              rsp_valid_o,
  input  logic              rsp_ready_i,
  output logic              rsp_hit_o,
  output logic              rsp_err_o,
  output logic [IDX_W-1:0]  rsp_frame_o,
  output logic [IDX_W:0]    rsp_count_o
);
  localparam logic [IDX_W:0] VISIT_MAX = (IDX_W+1)'(FRAMES);

  walk_st_e          st_q;
  logic [ASID_W-1:0] asid_q;
  logic [VPN_W-1:0]  vpn_q;
  logic [BKT_W-1:0]  bkt_q;
  logic [IDX_W-1:0]  cur_q;
  logic [IDX_W:0]    cnt_q;
  logic              hit_q, err_q;
  logic [IDX_W:0]    cnt_nx;
  logic              match;

  assign cnt_nx = cnt_q + 1'b1;
  assign match  = ent_valid_i && (ent_asid_i == asid_q) && (ent_vpn_i == vpn_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      asid_q <= '0;
      vpn_q  <= '0;
      bkt_q  <= '0;
      cur_q  <= '0;
      cnt_q  <= '0;
      hit_q  <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (req_valid_i) begin
          asid_q <= req_asid_i;
          vpn_q  <= req_vpn_i;
          bkt_q  <= req_bkt_i;
          cnt_q  <= '0;
          hit_q  <= 1'b0;
          err_q  <= 1'b0;
          st_q   <= ST_HEAD;
        end
        ST_HEAD: begin
          if (head_i[IDX_W]) st_q <= ST_RESP;
          else begin
            cur_q <= head_i[IDX_W-1:0];
            st_q  <= ST_WALK;
          end
        end
        ST_WALK: begin
          cnt_q <= cnt_nx;
          if (match) begin
            hit_q <= 1'b1;
            st_q  <= ST_RESP;
          end else if (ent_next_i[IDX_W]) begin
            st_q <= ST_RESP;
          end else if (cnt_nx == VISIT_MAX) begin
            err_q <= 1'b1;   // looping chain
            st_q  <= ST_RESP;
          end else begin
            cur_q <= ent_next_i[IDX_W-1:0];
          end
        end
        ST_RESP: if (rsp_ready_i) st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign idle_o      = (st_q == ST_IDLE);
  assign head_sel_o  = bkt_q;
  assign ent_sel_o   = cur_q;
  assign rsp_valid_o = (st_q == ST_RESP);
  assign rsp_hit_o   = hit_q;
  assign rsp_err_o   = err_q;
  assign rsp_frame_o = cur_q;
  assign rsp_count_o = cnt_q;
endmodule

// File: rtl/ipt_lookup.sv
module ipt_lookup #(
  parameter int FRAMES  = 256,
  parameter int BUCKETS = 64,
  parameter int ASID_W  = 16,
  parameter int VPN_W   = 36,
  localparam int IDX_W  = $clog2(FRAMES),
  localparam int BKT_W  = $clog2(BUCKETS),
  localparam int LINK_W = IDX_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [ASID_W-1:0] req_asid_i,
  input  logic [VPN_W-1:0]  req_vpn_i,
  output logic              rsp_valid_o,
  input  logic              rsp_ready_i,
  output logic              rsp_hit_o,
  output logic              rsp_err_o,
  output logic [IDX_W-1:0]  rsp_frame_o,
  output logic [IDX_W:0]    rsp_count_o,
  input  logic              wr_en_i,
  input  logic              wr_head_i,
  input  logic [IDX_W-1:0]  wr_addr_i,
  input  logic              wr_valid_i,
  input  logic [ASID_W-1:0] wr_asid_i,
  input  logic [VPN_W-1:0]  wr_vpn_i,
  input  logic [LINK_W-1:0] wr_next_i
);
  logic              idle;
  logic [BKT_W-1:0]  req_bkt, head_sel;
  logic [LINK_W-1:0] head_link, ent_next;
  logic [IDX_W-1:0]  ent_sel;
  logic              ent_valid;
  logic [ASID_W-1:0] ent_asid;
  logic [VPN_W-1:0]  ent_vpn;

  ipt_hash #(.ASID_W(ASID_W), .VPN_W(VPN_W), .BKT_W(BKT_W)) u_hash (
    .asid_i(req_asid_i), .vpn_i(req_vpn_i), .bkt_o(req_bkt)
  );

  ipt_store #(.FRAMES(FRAMES), .BUCKETS(BUCKETS), .ASID_W(ASID_W), .VPN_W(VPN_W)) u_store (
    .clk_i, .rst_ni,
    .wr_en_i(wr_en_i && idle), .wr_head_i, .wr_addr_i, .wr_valid_i,
    .wr_asid_i, .wr_vpn_i, .wr_next_i,
    .head_sel_i(head_sel), .head_o(head_link),
    .ent_sel_i(ent_sel), .ent_valid_o(ent_valid), .ent_asid_o(ent_asid),
    .ent_vpn_o(ent_vpn), .ent_next_o(ent_next)
  );

  ipt_walker #(.FRAMES(FRAMES), .BUCKETS(BUCKETS), .ASID_W(ASID_W), .VPN_W(VPN_W)) u_walk (
    .clk_i, .rst_ni,
    .req_valid_i, .req_asid_i, .req_vpn_i, .req_bkt_i(req_bkt),
    .idle_o(idle), .head_sel_o(head_sel), .head_i(head_link),
    .ent_sel_o(ent_sel), .ent_valid_i(ent_valid), .ent_asid_i(ent_asid),
    .ent_vpn_i(ent_vpn), .ent_next_i(ent_next),
    .rsp_valid_o, .rsp_ready_i, .rsp_hit_o, .rsp_err_o, .rsp_frame_o, .rsp_count_o
  );

  assign req_ready_o = idle;
endmodule

// File: rtl/ipt_lookup_chk.sv
module ipt_lookup_chk #(
  parameter int FRAMES = 256,
  localparam int IDX_W = $clog2(FRAMES)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_valid_i,
  input logic             req_ready_o,
  input logic             rsp_valid_o,
  input logic             rsp_ready_i,
  input logic             rsp_hit_o,
  input logic             rsp_err_o,
  input logic [IDX_W-1:0] rsp_frame_o,
  input logic [IDX_W:0]   rsp_count_o
);
  assert_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && !rsp_ready_i |=> rsp_valid_o && $stable(rsp_hit_o) && $stable(rsp_err_o)
      && $stable(rsp_frame_o) && $stable(rsp_count_o));

  assert_busy_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_ready_o && rsp_valid_o));

  assert_accept_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_ready_o |=> !req_ready_o && !rsp_valid_o);

  assert_excl_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> !(rsp_hit_o && rsp_err_o));

  assert_limit_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && rsp_err_o |-> rsp_count_o == (IDX_W+1)'(FRAMES));

  assert_hitcnt_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && rsp_hit_o |-> rsp_count_o != '0);
endmodule

bind ipt_lookup ipt_lookup_chk #(.FRAMES(FRAMES)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_valid_i(req_valid_i), .req_ready_o(req_ready_o),
  .rsp_valid_o(rsp_valid_o), .rsp_ready_i(rsp_ready_i), .rsp_hit_o(rsp_hit_o),
  .rsp_err_o(rsp_err_o), .rsp_frame_o(rsp_frame_o), .rsp_count_o(rsp_count_o)
);

// File: tb/ipt_lookup_tb.sv
`timescale 1ns/1ps
module ipt_lookup_tb;
  localparam int FRAMES = 16, BUCKETS = 4, ASID_W = 4, VPN_W = 8;
  localparam int IDX_W = 4, BKT_W = 2, LINK_W = 5;
  localparam logic [LINK_W-1:0] LEND = 5'b10000;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, rsp_ready = 0;
  logic [ASID_W-1:0] req_asid = 0;
  logic [VPN_W-1:0] req_vpn = 0;
  logic req_ready, rsp_valid, rsp_hit, rsp_err;
  logic [IDX_W-1:0] rsp_frame;
  logic [IDX_W:0] rsp_count;
  logic wr_en = 0, wr_head = 0, wr_valid = 0;
  logic [IDX_W-1:0] wr_addr = 0;
  logic [ASID_W-1:0] wr_asid = 0;
  logic [VPN_W-1:0] wr_vpn = 0;
  logic [LINK_W-1:0] wr_next = 0;

  int n_chk = 0, n_fail = 0, cyc = 0;

  logic [LINK_W-1:0] m_head [BUCKETS];
  logic              m_vld  [FRAMES];
  logic [ASID_W-1:0] m_asid [FRAMES];
  logic [VPN_W-1:0]  m_vpn  [FRAMES];
  logic [LINK_W-1:0] m_next [FRAMES];

  ipt_lookup #(.FRAMES(FRAMES), .BUCKETS(BUCKETS), .ASID_W(ASID_W), .VPN_W(VPN_W)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_asid_i(req_asid), .req_vpn_i(req_vpn), .rsp_valid_o(rsp_valid), .rsp_ready_i(rsp_ready),
    .rsp_hit_o(rsp_hit), .rsp_err_o(rsp_err), .rsp_frame_o(rsp_frame), .rsp_count_o(rsp_count),
    .wr_en_i(wr_en), .wr_head_i(wr_head), .wr_addr_i(wr_addr), .wr_valid_i(wr_valid),
    .wr_asid_i(wr_asid), .wr_vpn_i(wr_vpn), .wr_next_i(wr_next)
  );

  always #10 clk = ~clk;

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      finish_run();
    end
  end

  task automatic check(input bit ok, input string rq, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
    end
  endtask

  // R2 fold as XOR of 2-bit slices of {asid,vpn}
  function automatic logic [BKT_W-1:0] bhash(input logic [ASID_W-1:0] a, input logic [VPN_W-1:0] v);
    logic [ASID_W+VPN_W-1:0] k = {a, v};
    logic [BKT_W-1:0] h = '0;
    for (int s = 0; s < (ASID_W+VPN_W)/BKT_W; s++) h ^= k[s*BKT_W +: BKT_W];
    return h;
  endfunction

  task automatic model_walk(input logic [ASID_W-1:0] a, input logic [VPN_W-1:0] v,
                            output bit hit, output bit err, output int frame, output int cnt);
    logic [LINK_W-1:0] l = m_head[bhash(a, v)];
    hit = 0; err = 0; frame = 0; cnt = 0;
    while (!l[IDX_W]) begin
      int i = int'(l[IDX_W-1:0]);
      cnt++;
      if (m_vld[i] && m_asid[i] == a && m_vpn[i] == v) begin hit = 1; frame = i; return; end
      if (m_next[i][IDX_W]) return;
      if (cnt == FRAMES) begin err = 1; return; end
      l = m_next[i];
    end
  endtask

  task automatic wr_entry(input int idx, input bit v, input int a, input int p, input logic [LINK_W-1:0] nx);
    @(negedge clk);
    wr_en = 1; wr_head = 0; wr_addr = IDX_W'(idx); wr_valid = v;
    wr_asid = ASID_W'(a); wr_vpn = VPN_W'(p); wr_next = nx;
    @(posedge clk); #1;
    wr_en = 0;
    m_vld[idx] = v; m_asid[idx] = ASID_W'(a); m_vpn[idx] = VPN_W'(p); m_next[idx] = nx;
  endtask

  task automatic wr_head_t(input int b, input logic [LINK_W-1:0] l);
    @(negedge clk);
    wr_en = 1; wr_head = 1; wr_addr = IDX_W'(b); wr_next = l;
    @(posedge clk); #1;
    wr_en = 0;
    m_head[b] = l;
  endtask

  // hold: cycles to keep rsp_ready low; inject: attempt a head write mid-walk (R10)
  task automatic lookup(input int a, input int p, input int hold, input bit inject, input string rq);
    bit eh, ee; int ef, ec, lat;
    model_walk(ASID_W'(a), VPN_W'(p), eh, ee, ef, ec);
    @(negedge clk);
    req_valid = 1; req_asid = ASID_W'(a); req_vpn = VPN_W'(p);
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;
    if (inject) begin
      wr_en = 1; wr_head = 1; wr_addr = IDX_W'(bhash(ASID_W'(a), VPN_W'(p))); wr_next = LEND;
    end
    lat = 0;
    do begin
      @(posedge clk); lat++;
      @(negedge clk); wr_en = 0;
    end while (!rsp_valid && lat < 40);
    check(lat == ec + 1, "R8", "latency", lat, ec + 1);
    check(rsp_hit == eh, rq, "hit", int'(rsp_hit), int'(eh));
    check(rsp_err == ee, "R7", "err", int'(rsp_err), int'(ee));
    check(int'(rsp_count) == ec, rq, "count", int'(rsp_count), ec);
    if (eh) check(int'(rsp_frame) == ef, "R3", "frame", int'(rsp_frame), ef);
    for (int h = 0; h < hold; h++) begin
      @(negedge clk);
      check(rsp_valid && !req_ready, "R9", "held valid/busy", int'({rsp_valid, req_ready}), 2);
      check(int'(rsp_count) == ec && rsp_hit == eh, "R9", "held count", int'(rsp_count), ec);
    end
    rsp_ready = 1;
    @(posedge clk);
    @(negedge clk);
    rsp_ready = 0;
    check(!rsp_valid && req_ready, "R9", "released", int'({rsp_valid, req_ready}), 1);
  endtask

  initial begin
    for (int b = 0; b < BUCKETS; b++) m_head[b] = LEND;
    for (int f = 0; f < FRAMES; f++) begin
      m_vld[f] = 0; m_asid[f] = 0; m_vpn[f] = 0; m_next[f] = LEND;
    end
    repeat (3) @(negedge clk);
    check(req_ready == 1, "R1", "req_ready in reset", int'(req_ready), 1);
    check(rsp_valid == 0, "R1", "rsp_valid in reset", int'(rsp_valid), 0);
    rst_n = 1;
    lookup(0, 0, 0, 0, "R1");
    lookup(7, 99, 0, 0, "R1");

    // R11: fill frames 0..13 by prepending to their bucket chains
    for (int f = 0; f < 14; f++) begin
      int a = f % 4, p = f * 9 + 3;
      int b = int'(bhash(ASID_W'(a), VPN_W'(p)));
      wr_entry(f, 1, a, p, m_head[b]);
      wr_head_t(b, LINK_W'(f));
    end
    for (int f = 0; f < 14; f++) lookup(f % 4, f * 9 + 3, 0, 0, "R3");

    // R2 R4 R5: sweep of keys (hits and misses on every bucket)
    for (int a = 0; a < 4; a++)
      for (int p = 0; p < 256; p++) lookup(a, p, 0, 0, (a == 0 && p == 3) ? "R2" : "R5");
    lookup(1, 3, 0, 0, "R4");   // vpn of frame 0 under another asid

    // R4: invalidated slot keeps its link but no longer matches
    wr_entry(5, 0, 5 % 4, 5 * 9 + 3, m_next[5]);
    lookup(1, 48, 0, 0, "R4");
    for (int f = 0; f < 14; f++) lookup(f % 4, f * 9 + 3, 0, 0, "R4");

    // R9: response held over stalled ready
    lookup(2, 21, 3, 0, "R9");
    lookup(3, 200, 2, 0, "R9");

    // R10: head write during a walk is dropped
    lookup(0, 39, 0, 1, "R10");
    lookup(0, 39, 0, 0, "R10");
    lookup(2, 21, 0, 1, "R10");
    lookup(2, 21, 0, 0, "R10");

    // R6: end marker with nonzero low bits
    wr_head_t(int'(bhash(4'd9, 8'd9)), 5'b10101);
    lookup(9, 9, 0, 0, "R6");

    // R7: two-slot loop; search key matches neither
    wr_entry(14, 1, 15, 255, 5'd15);
    wr_entry(15, 1, 15, 254, 5'd14);
    wr_head_t(int'(bhash(4'd15, 8'd253)), 5'd14);
    lookup(15, 253, 0, 0, "R7");
    lookup(15, 254, 1, 0, "R3");
    finish_run();
  end
endmodule